// File: doc/BRIEF.md
# Configuration Register Bank with Freeze

This block is the byte-wide register bank behind the control port of a clock generator. It has three device registers at addresses 02h, 03h and 04h and one global register at 05h. All of them are reached through a simple synchronous port: address, write data, write strobe and combinational read data.

Every write to a device register lands in a staging copy. While the global freeze flag is clear, the same write also updates the live copy that drives the outputs. While freeze is set, the live copies hold their old values. On the clock edge that clears freeze, all staged bytes move into the live registers together. A read of a device address returns the staged byte, so software can check pending values before it releases them.

The live copy of 04h holds three settings:
- the first half of a two-bit enable interlock for control-port mode;
- a two-bit selector that picks which of four 1-bit sources drives the auxiliary output;
- a polarity bit that applies when the lock indicator is the selected source.

Top module: `cfgb_top`

## Requirements
- R1: A synchronous active-high reset clears every staged and live register, the freeze flag and the second enable bit. After reset every address reads 00h, `dev_live` is all zero, `ctrl_port_en` is 0, and `aux_out` follows `src_in[0]`.
- R2: While freeze is 0, a write to 02h, 03h or 04h updates that register's live byte on the same clock edge. The live byte for address 02h+i is `dev_live[8*i+7:8*i]`. A read of the address then returns the written byte.
- R3: While freeze is 1, a write to 02h–04h changes only the staged byte. The live byte keeps its old value, and a read of the address returns the newly written byte.
- R4: On the edge where a write to 05h clears a set freeze bit, every staged device byte is copied into its live byte at once.
- R5: Register 05h holds freeze at bit 3 and the second enable at bit 0. Its bits 7:4, 2 and 1 ignore writes and read as 0.
- R6: A write to any address other than 02h–05h changes no register. A read of such an address returns 00h.
- R7: `ctrl_port_en` is 1 only when live 04h bit 0 and 05h bit 0 are both 1.
- R8: Live 04h bits 2:1 select the auxiliary source:
  - 00 selects `src_in[0]` (reference clock);
  - 01 selects `src_in[1]` (clock input);
  - 10 selects `src_in[2]` (clock output);
  - 11 selects `src_in[3]` (lock indicator).
- R9: When the selector is 11, live 04h bit 3 sets the lock polarity. A value of 0 passes `src_in[3]` unchanged; a value of 1 inverts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one write per cycle |
| rdata | output | 8 | Combinational read data for `addr` |
| src_in | input | 4 | Auxiliary sources: ref clock, clock in, clock out, lock |
| aux_out | output | 1 | Selected auxiliary source |
| ctrl_port_en | output | 1 | Control-port mode enable |
| dev_live | output | 24 | Live bytes of 02h (bits 7:0), 03h (bits 15:8), 04h (bits 23:16) |

## Verification
The assertions check three rules on every cycle:
- an open write reaches the live byte on the following edge;
- the live bytes stay still while freeze is held;
- a release delivers exactly the staged bytes, and writes to unmapped addresses leave both the device bytes and the global flags unchanged.

The readback of staged values, the reserved-bit masking at 05h, the enable interlock and the full source and polarity table of the auxiliary mux are shown only by the bench's directed scenarios. Those scenarios compare port values against expectations worked out from the requirements.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
    localparam int CFG_AW    = 8;
    localparam int CFG_DW    = 8;
    localparam int CFG_NDEV  = 3;
    localparam int CFG_BASE  = 2;
    localparam int CFG_GADDR = 5;
    localparam int FRZ_BIT   = 3;
    localparam int EN2_BIT   = 0;
    localparam int EN1_BIT   = 0;
    localparam int SEL_LSB   = 1;
    localparam int POL_BIT   = 3;
    localparam int CFG_NSRC  = 4;

    typedef struct packed {
        logic frz;
        logic en2;
    } glob_state_t;
endpackage

// File: rtl/cfgb_dev_regs.sv
module cfgb_dev_regs #(
    parameter int NDEV = 3,
    parameter int DW   = 8,
    parameter int AW   = 8,
    parameter int BASE = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [AW-1:0]            addr,
    input  logic [DW-1:0]            wdata,
    input  logic                     frz_i,
    input  logic                     rel_i,
    output logic [NDEV-1:0][DW-1:0]  stage_o,
    output logic [NDEV-1:0][DW-1:0]  live_o
);
    typedef struct packed {
        logic [NDEV-1:0][DW-1:0] stage;
        logic [NDEV-1:0][DW-1:0] live;
    } dev_state_t;

    dev_state_t st_d, st_q;
    logic [NDEV-1:0] hit;

    always_comb begin
        for (int i = 0; i < NDEV; i++) begin
            hit[i] = wr_en && (addr == AW'(BASE + i));
        end
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NDEV; i++) begin
            if (hit[i]) begin
                st_d.stage[i] = wdata;
            end
        end
        if (rel_i) begin
            st_d.live = st_q.stage;
        end else if (!frz_i) begin
            for (int i = 0; i < NDEV; i++) begin
                if (hit[i]) begin
                    st_d.live[i] = wdata;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stage_o = st_q.stage;
    assign live_o  = st_q.live;

    // Open writes land on the following edge.
    for (genvar g = 0; g < NDEV; g++) begin : g_chk
        p_open_write_r2: assert property (@(posedge clk) disable iff (rst)
            (wr_en && addr == AW'(BASE + g) && !frz_i && !rel_i)
            |=> (live_o[g] == $past(wdata)));
    end

    // While freeze is held, the live bytes do not move.
    p_frozen_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (frz_i && !rel_i) |=> $stable(live_o));

    // A release delivers the staged bytes.
    p_release_copy_r4: assert property (@(posedge clk) disable iff (rst)
        rel_i |=> (live_o == $past(stage_o)));
endmodule

// File: rtl/cfgb_glob_reg.sv
module cfgb_glob_reg
    import cfgb_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_i,
    input  logic          frz_bit_i,
    input  logic          en2_bit_i,
    output logic          frz_o,
    output logic          en2_o,
    output logic          rel_o,
    output logic [DW-1:0] rdata_o
);
    glob_state_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (wr_i) begin
            g_d.frz = frz_bit_i;
            g_d.en2 = en2_bit_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign frz_o = g_q.frz;
    assign en2_o = g_q.en2;
    assign rel_o = g_q.frz && !g_d.frz;

    always_comb begin
        rdata_o          = '0;
        rdata_o[FRZ_BIT] = g_q.frz;
        rdata_o[EN2_BIT] = g_q.en2;
    end
endmodule

// File: rtl/cfgb_aux_mux.sv
module cfgb_aux_mux #(
    parameter int NSRC = 4
) (
    input  logic [NSRC-1:0]         src_i,
    input  logic [$clog2(NSRC)-1:0] sel_i,
    input  logic                    pol_i,
    output logic                    aux_o
);
    localparam int SELW = $clog2(NSRC);
    localparam logic [SELW-1:0] LOCK_IDX = SELW'(NSRC - 1);

    always_comb begin
        aux_o = src_i[sel_i];
        if (sel_i == LOCK_IDX) begin
            aux_o = src_i[sel_i] ^ pol_i;
        end
    end
endmodule

// File: rtl/cfgb_top.sv
module cfgb_top
    import cfgb_pkg::*;
#(
    parameter int AW    = CFG_AW,
    parameter int DW    = CFG_DW,
    parameter int NDEV  = CFG_NDEV,
    parameter int BASE  = CFG_BASE,
    parameter int GADDR = CFG_GADDR,
    parameter int NSRC  = CFG_NSRC
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [AW-1:0]      addr,
    input  logic [DW-1:0]      wdata,
    input  logic               wr_en,
    output logic [DW-1:0]      rdata,
    input  logic [NSRC-1:0]    src_in,
    output logic               aux_out,
    output logic               ctrl_port_en,
    output logic [NDEV*DW-1:0] dev_live
);
    localparam int SELW   = $clog2(NSRC);
    localparam int CFG_IX = NDEV - 1;

    logic [NDEV-1:0][DW-1:0] stage, live;
    logic [DW-1:0]           glob_rd;
    logic                    frz, en2, rel, glob_wr, mapped;

    assign glob_wr = wr_en && (addr == AW'(GADDR));

    cfgb_glob_reg #(.DW(DW)) u_glob (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (glob_wr),
        .frz_bit_i (wdata[FRZ_BIT]),
        .en2_bit_i (wdata[EN2_BIT]),
        .frz_o     (frz),
        .en2_o     (en2),
        .rel_o     (rel),
        .rdata_o   (glob_rd)
    );

    cfgb_dev_regs #(.NDEV(NDEV), .DW(DW), .AW(AW), .BASE(BASE)) u_dev (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .frz_i   (frz),
        .rel_i   (rel),
        .stage_o (stage),
        .live_o  (live)
    );

    cfgb_aux_mux #(.NSRC(NSRC)) u_aux (
        .src_i (src_in),
        .sel_i (live[CFG_IX][SEL_LSB +: SELW]),
        .pol_i (live[CFG_IX][POL_BIT]),
        .aux_o (aux_out)
    );

    assign ctrl_port_en = live[CFG_IX][EN1_BIT] && en2;
    assign dev_live     = live;

    always_comb begin
        rdata  = '0;
        mapped = 1'b0;
        for (int i = 0; i < NDEV; i++) begin
            if (addr == AW'(BASE + i)) begin
                rdata  = stage[i];
                mapped = 1'b1;
            end
        end
        if (addr == AW'(GADDR)) begin
            rdata  = glob_rd;
            mapped = 1'b1;
        end
    end

    // Writes to unmapped addresses leave all state alone.
    p_unmapped_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !mapped) |=> ($stable(dev_live) && $stable(frz) && $stable(en2)));
endmodule

// File: tb/tb_cfgb_top.sv
module tb_cfgb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  addr;
    logic [7:0]  wdata;
    logic        wr_en;
    logic [7:0]  rdata;
    logic [3:0]  src_in;
    logic        aux_out;
    logic        ctrl_port_en;
    logic [23:0] dev_live;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgb_top dut (
        .clk          (clk),
        .rst          (rst),
        .addr         (addr),
        .wdata        (wdata),
        .wr_en        (wr_en),
        .rdata        (rdata),
        .src_in       (src_in),
        .aux_out      (aux_out),
        .ctrl_port_en (ctrl_port_en),
        .dev_live     (dev_live)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b0;
        addr  = a;
        #1;
        d = rdata;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 live", dev_live, 24'h0);
        chk("R1 ctrl", ctrl_port_en, 0);
        for (int a = 2; a <= 5; a++) begin
            rd(8'(a), v);
            chk("R1 read", v, 0);
        end
        src_in = 4'b0001;
        #1;
        chk("R1 aux", aux_out, 1);
        src_in = 4'b1110;
        #1;
        chk("R1 aux0", aux_out, 0);
    endtask

    task automatic t_open;
        logic [7:0] v;
        wr(8'h02, 8'hA5);
        chk("R2 live02", dev_live[7:0], 8'hA5);
        rd(8'h02, v);
        chk("R2 read02", v, 8'hA5);
    endtask

    task automatic t_frozen;
        logic [7:0] v;
        wr(8'h05, 8'h08);
        wr(8'h03, 8'h3C);
        wr(8'h02, 8'h11);
        chk("R3 live03 held", dev_live[15:8], 8'h00);
        chk("R3 live02 held", dev_live[7:0], 8'hA5);
        rd(8'h03, v);
        chk("R3 staged03", v, 8'h3C);
        rd(8'h02, v);
        chk("R3 staged02", v, 8'h11);
    endtask

    task automatic t_release;
        wr(8'h05, 8'h00);
        chk("R4 release", dev_live, {8'h00, 8'h3C, 8'h11});
    endtask

    task automatic t_glob;
        logic [7:0] v;
        wr(8'h05, 8'hFF);
        rd(8'h05, v);
        chk("R5 reserved", v, 8'h09);
        wr(8'h02, 8'h22);
        chk("R5 freeze bit3", dev_live[7:0], 8'h11);
        wr(8'h05, 8'hF7);
        chk("R5 clear releases", dev_live[7:0], 8'h22);
        rd(8'h05, v);
        chk("R5 en2 only", v, 8'h01);
    endtask

    task automatic t_unmapped;
        logic [7:0] v;
        wr(8'h06, 8'hFF);
        wr(8'h01, 8'hFF);
        wr(8'h00, 8'hFF);
        wr(8'hFF, 8'hFF);
        chk("R6 live", dev_live, {8'h00, 8'h3C, 8'h22});
        rd(8'h06, v);
        chk("R6 read06", v, 0);
        rd(8'h01, v);
        chk("R6 read01", v, 0);
        rd(8'h05, v);
        chk("R6 glob kept", v, 8'h01);
    endtask

    task automatic t_interlock;
        chk("R7 en1 off", ctrl_port_en, 0);
        wr(8'h04, 8'h01);
        chk("R7 both", ctrl_port_en, 1);
        wr(8'h05, 8'h00);
        chk("R7 en2 off", ctrl_port_en, 0);
        wr(8'h05, 8'h01);
        chk("R7 back", ctrl_port_en, 1);
        wr(8'h04, 8'h00);
        chk("R7 en1 cleared", ctrl_port_en, 0);
    endtask

    task automatic t_aux(input bit pol);
        for (int s = 0; s < 4; s++) begin
            wr(8'h04, 8'((int'(pol) << 3) | (s << 1) | 1));
            for (int p = 0; p < 8; p++) begin
                logic [3:0] pat;
                logic       exp;
                pat = (p < 4) ? 4'(1 << p) : ~4'(1 << (p - 4));
                src_in = pat;
                #1;
                exp = pat[s];
                if (s == 3) exp = pat[3] ^ pol;
                chk(pol ? "R9 polarity" : "R8 select", aux_out, exp);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        addr   = '0;
        wdata  = '0;
        wr_en  = 1'b0;
        src_in = '0;
        t_reset();
        t_open();
        t_frozen();
        t_release();
        t_glob();
        t_unmapped();
        t_interlock();
        t_aux(1'b0);
        t_aux(1'b1);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule